// File: doc/BRIEF.md
# Generator Address Marshal Buffer

This block sits beside one core and keeps a short list of the cache blocks that the running code segment produced for the next segment. Every store that the pipeline marks as a generator store presents its cache-block address; the block adds that address to its list unless it is already there. Ordinary stores pass through without effect.

When the core issues a marshal command naming a destination core, the block streams every recorded address, oldest first, as (destination, block address) pairs on a valid/ready output. The cache push engine downstream uses them to fill the destination core's cache before the next segment starts there. Once the last pair is taken the list is empty, ready for the next segment. While a burst is in flight, new stores and new commands are held off. If more distinct blocks arrive than the list can hold, the extra ones are dropped and a flag is raised. Losing them costs locality only, never correctness.

Top module: `gen_marshal_buf`

## Requirements
- R1: After reset, entryCount is 0, overflow is 0, outValid is 0, and both stReady and mshReady are 1.
- R2: A store accepted with stIsGen=1 whose block address is not in the list appends it; entryCount rises by one in the next cycle.
- R3: A store accepted with stIsGen=0 changes neither entryCount nor the list contents.
- R4: A generator store whose block address equals one already in the list adds no entry, and entryCount stays the same.
- R5: The list holds DEPTH (16) addresses. A generator store with a new address while entryCount equals DEPTH is dropped and sets overflow to 1. A repeat of a stored address when the list is full leaves overflow at 0.
- R6: A marshal command is accepted when mshValid and mshReady are both 1. From the next cycle, outValid is 1 and each recorded address appears on outAddr in recording order, with outDest equal to the command's mshDest. The output advances by one address for each cycle with outValid and outReady both 1.
- R7: While outValid is 1 and outReady is 0, outValid, outAddr and outDest keep their values.
- R8: From command acceptance until the last pair is taken, stReady and mshReady are 0, and a store offered then is not recorded. In the cycle after the last pair is taken, entryCount is 0, overflow is 0, and both readies are 1.
- R9: A marshal command while the list is empty produces no output pair; mshReady returns to 1 two cycles after acceptance and entryCount stays 0.
- R10: A generator store accepted in the same cycle as a marshal command is recorded and sent as the last pair of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store event present |
| stIsGen | input | 1 | Store is tagged as a generator store |
| stAddr | input | ADDR_W (48) | Cache-block address written by the store |
| stReady | output | 1 | Store event accepted this cycle when stValid is 1 |
| mshValid | input | 1 | Marshal command present |
| mshDest | input | CORE_W (6) | Destination core of the marshal command |
| mshReady | output | 1 | Marshal command accepted this cycle when mshValid is 1 |
| outValid | output | 1 | An outgoing (destination, address) pair is present |
| outReady | input | 1 | Downstream takes the pair this cycle |
| outDest | output | CORE_W (6) | Destination core of the pair |
| outAddr | output | ADDR_W (48) | Block address of the pair |
| entryCount | output | CNT_W (5) | Number of recorded addresses |
| overflow | output | 1 | A generator address was dropped since the last burst |

## Verification
Two functions can fall in the same cycle: recording a generator store and accepting a marshal command. Both readies are high when the block is idle, so the bench raises stValid and mshValid on the same edge. It then expects the new block to come out as the final pair of that burst. The opposite case is also covered. A store that is held valid through a whole burst must never be accepted, and the list must be empty afterwards. Duplicate detection against a full list is judged by watching overflow stay low for a repeated address and rise for a new one.

// File: rtl/gmb_pkg.sv
package gmb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;       // write stAddr into slot entryCount
    logic latchDest;  // capture destination of an accepted command
  } gmbStrobe_t;
endpackage

// File: rtl/gmb_ctrl.sv
module gmb_ctrl
  import gmb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             stIsGen,
  input  logic             mshValid,
  input  logic             outReady,
  input  logic             hit,
  output logic             stReady,
  output logic             mshReady,
  output logic             outValid,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] entryCount,
  output logic             overflow,
  output gmbStrobe_t       strobe
);
  logic draining;
  logic stFire, genEvt, isFull, wrEn, ovfSet;
  logic mshFire, outFire, lastOut, drainDone;

  always_comb begin
    stReady   = !draining;
    mshReady  = !draining;
    stFire    = stValid && stReady;
    genEvt    = stFire && stIsGen;
    isFull    = (entryCount == CNT_W'(DEPTH));
    wrEn      = genEvt && !hit && !isFull;
    ovfSet    = genEvt && !hit && isFull;
    mshFire   = mshValid && mshReady;
    outValid  = draining && (entryCount != '0);
    outFire   = outValid && outReady;
    lastOut   = outFire && (CNT_W'(rdPtr) == entryCount - CNT_W'(1));
    drainDone = draining && ((entryCount == '0) || lastOut);
    strobe.wrEn      = wrEn;
    strobe.latchDest = mshFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      draining   <= 1'b0;
      rdPtr      <= '0;
      entryCount <= '0;
      overflow   <= 1'b0;
    end else if (drainDone) begin
      draining   <= 1'b0;
      rdPtr      <= '0;
      entryCount <= '0;
      overflow   <= 1'b0;
    end else begin
      if (mshFire) begin
        draining <= 1'b1;
        rdPtr    <= '0;
      end
      if (wrEn)    entryCount <= entryCount + CNT_W'(1);
      if (ovfSet)  overflow   <= 1'b1;
      if (outFire) rdPtr      <= rdPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/gmb_datapath.sv
module gmb_datapath
  import gmb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter int CORE_W = 6,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gmbStrobe_t        strobe,
  input  logic [CNT_W-1:0]  entryCount,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [CORE_W-1:0] mshDest,
  output logic              hit,
  output logic [ADDR_W-1:0] outAddr,
  output logic [CORE_W-1:0] outDest
);
  logic [ADDR_W-1:0] slots [DEPTH];
  logic [DEPTH-1:0]  matchVec;
  logic [CORE_W-1:0] destReg;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (entryCount == CNT_W'(i))) slots[i] <= stAddr;
    end
    assign matchVec[i] = (CNT_W'(i) < entryCount) && (slots[i] == stAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 destReg <= '0;
    else if (strobe.latchDest) destReg <= mshDest;
  end

  assign hit     = |matchVec;
  assign outAddr = slots[rdPtr];
  assign outDest = destReg;
endmodule

// File: rtl/gen_marshal_buf.sv
module gen_marshal_buf
  import gmb_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int ADDR_W = 48,
  parameter  int CORE_W = 6,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic              stIsGen,
  input  logic [ADDR_W-1:0] stAddr,
  output logic              stReady,
  input  logic              mshValid,
  input  logic [CORE_W-1:0] mshDest,
  output logic              mshReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [CORE_W-1:0] outDest,
  output logic [ADDR_W-1:0] outAddr,
  output logic [CNT_W-1:0]  entryCount,
  output logic              overflow
);
  gmbStrobe_t       strobe;
  logic             hit;
  logic [PTR_W-1:0] rdPtr;

  gmb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stIsGen(stIsGen), .mshValid(mshValid),
    .outReady(outReady), .hit(hit),
    .stReady(stReady), .mshReady(mshReady), .outValid(outValid),
    .rdPtr(rdPtr), .entryCount(entryCount), .overflow(overflow),
    .strobe(strobe)
  );

  gmb_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CORE_W(CORE_W),
                 .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .entryCount(entryCount), .rdPtr(rdPtr),
    .stAddr(stAddr), .mshDest(mshDest),
    .hit(hit), .outAddr(outAddr), .outDest(outDest)
  );
endmodule

// File: rtl/gmb_checker.sv
module gmb_checker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter int CORE_W = 6,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stReady,
  input logic              mshReady,
  input logic              outValid,
  input logic              outReady,
  input logic [CORE_W-1:0] outDest,
  input logic [ADDR_W-1:0] outAddr,
  input logic [CNT_W-1:0]  entryCount,
  input logic              overflow
);
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !stReady && !mshReady); // R8
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outDest)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CNT_W'(DEPTH)); // R5
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> entryCount == CNT_W'(DEPTH)); // R5
  AST_EMPTY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mshReady) |-> entryCount == '0 && !overflow); // R8
  AST_NO_GROW_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |=> entryCount <= $past(entryCount)); // R8
endmodule

bind gen_marshal_buf gmb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_chk (
  .clk(clk), .rstN(rstN), .stReady(stReady), .mshReady(mshReady),
  .outValid(outValid), .outReady(outReady), .outDest(outDest),
  .outAddr(outAddr), .entryCount(entryCount), .overflow(overflow)
);

// File: tb/gen_marshal_buf_bench.sv
module gen_marshal_buf_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        stValid, stIsGen, mshValid, outReady;
  logic [47:0] stAddr, outAddr;
  logic [5:0]  mshDest, outDest;
  logic        stReady, mshReady, outValid, overflow;
  logic [4:0]  entryCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [47:0] expAddr [32];

  always #2 clk = ~clk;  // 250 MHz

  gen_marshal_buf u_gen_marshal_buf (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stIsGen(stIsGen), .stAddr(stAddr),
    .stReady(stReady), .mshValid(mshValid), .mshDest(mshDest), .mshReady(mshReady),
    .outValid(outValid), .outReady(outReady), .outDest(outDest), .outAddr(outAddr),
    .entryCount(entryCount), .overflow(overflow)
  );

  typedef struct packed {
    logic        isGen;
    logic [47:0] addr;
    logic [4:0]  expCnt;
  } vec_t;

  // R2 R3 R4 stimulus: gen/ordinary stores and the expected count after each
  localparam vec_t VECS [8] = '{
    '{1'b1, 48'h1,       5'd1},   // R2 new
    '{1'b1, 48'h1,       5'd1},   // R4 repeat
    '{1'b0, 48'h2,       5'd1},   // R3 ordinary
    '{1'b1, 48'h2,       5'd2},   // R2 new
    '{1'b1, 48'h48D159F, 5'd3},   // R2 new
    '{1'b0, 48'h3,       5'd3},   // R3 ordinary
    '{1'b1, 48'h1,       5'd3},   // R4 repeat
    '{1'b1, 48'h3,       5'd4}    // R2 new
  };

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStore(input logic isGen, input logic [47:0] a);
    stValid = 1'b1; stIsGen = isGen; stAddr = a;
    @(posedge clk); @(negedge clk);
    stValid = 1'b0;
  endtask

  // storeMode: 0 none, 1 generator store in command cycle, 2 store held during burst
  task automatic runDrain(input logic [5:0] dest, input int n, input int stallAt,
                          input int storeMode, input logic [47:0] sAddr);
    mshValid = 1'b1; mshDest = dest;
    if (storeMode == 1) begin stValid = 1'b1; stIsGen = 1'b1; stAddr = sAddr; end
    @(posedge clk); @(negedge clk);
    mshValid = 1'b0;
    stValid  = 1'b0;
    if (storeMode == 2) begin stValid = 1'b1; stIsGen = 1'b1; stAddr = sAddr; end
    check(mshReady == 1'b0, "R8 mshReady low in burst", 64'(mshReady), 64'd0);
    for (int k = 0; k < n; k++) begin
      if (k == stallAt) begin
        outReady = 1'b0;
        for (int s = 0; s < 2; s++) begin
          check(outValid && outAddr == expAddr[k], "R7 held under stall",
                64'(outAddr), 64'(expAddr[k]));
          @(posedge clk); @(negedge clk);
        end
      end
      check(outValid == 1'b1, "R6 outValid", 64'(outValid), 64'd1);
      check(outAddr == expAddr[k], "R6 order", 64'(outAddr), 64'(expAddr[k]));
      check(outDest == dest, "R6 dest", 64'(outDest), 64'(dest));
      check(stReady == 1'b0, "R8 store held off", 64'(stReady), 64'd0);
      outReady = 1'b1;
      @(posedge clk); @(negedge clk);
      outReady = 1'b0;
    end
    stValid = 1'b0;
    check(outValid == 1'b0, "R8 no pair after burst", 64'(outValid), 64'd0);
    check(entryCount == 5'd0, "R8 empty after burst", 64'(entryCount), 64'd0);
    check(overflow == 1'b0, "R8 overflow cleared", 64'(overflow), 64'd0);
    check(stReady && mshReady, "R8 ready after burst", 64'({stReady, mshReady}), 64'h3);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0; stValid = 1'b0; stIsGen = 1'b0; stAddr = '0;
    mshValid = 1'b0; mshDest = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(entryCount == 5'd0, "R1 count", 64'(entryCount), 64'd0);
    check(overflow == 1'b0, "R1 overflow", 64'(overflow), 64'd0);
    check(outValid == 1'b0, "R1 outValid", 64'(outValid), 64'd0);
    check(stReady && mshReady, "R1 readies", 64'({stReady, mshReady}), 64'h3);

    // table walk: R2 R3 R4
    foreach (VECS[i]) begin
      doStore(VECS[i].isGen, VECS[i].addr);
      check(entryCount == VECS[i].expCnt, "R2/R3/R4 count",
            64'(entryCount), 64'(VECS[i].expCnt));
    end

    // R6 R7 R8: burst with a stall and a store held through it
    expAddr[0] = 48'h1; expAddr[1] = 48'h2; expAddr[2] = 48'h48D159F; expAddr[3] = 48'h3;
    runDrain(6'd5, 4, 0, 2, 48'h777);

    // R5: fill, repeat when full, drop when full
    for (int k = 0; k < 16; k++) begin
      expAddr[k] = 48'h100 + 48'(k);
      doStore(1'b1, expAddr[k]);
    end
    check(entryCount == 5'd16, "R5 full count", 64'(entryCount), 64'd16);
    doStore(1'b1, 48'h105);
    check(overflow == 1'b0, "R5 repeat when full", 64'(overflow), 64'd0);
    doStore(1'b1, 48'h200);
    check(overflow == 1'b1, "R5 overflow set", 64'(overflow), 64'd1);
    check(entryCount == 5'd16, "R5 drop keeps count", 64'(entryCount), 64'd16);
    runDrain(6'd63, 16, -1, 0, 48'h0);

    // R9: marshal with nothing recorded
    mshValid = 1'b1; mshDest = 6'd7;
    @(posedge clk); @(negedge clk);
    mshValid = 1'b0;
    check(outValid == 1'b0, "R9 no pair", 64'(outValid), 64'd0);
    @(posedge clk); @(negedge clk);
    check(outValid == 1'b0, "R9 no pair later", 64'(outValid), 64'd0);
    check(mshReady == 1'b1, "R9 ready again", 64'(mshReady), 64'd1);
    check(entryCount == 5'd0, "R9 count", 64'(entryCount), 64'd0);

    // R10: store and command in the same cycle
    doStore(1'b1, 48'h300);
    doStore(1'b1, 48'h301);
    expAddr[0] = 48'h300; expAddr[1] = 48'h301; expAddr[2] = 48'h302;
    runDrain(6'd9, 3, 2, 1, 48'h302);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule